// File: doc/BRIEF.md
# Latched Fault Protection and Supply Lockout Supervisor

This block is the digital protection core of a switching power controller. Four comparator flags come in from the analog front end: supply overvoltage, feedback above the overload threshold, junction over-temperature, and secondary-side over-current on the current sense pin. Three flags report the supply level against the lockout thresholds. The slow faults must stay present for a programmable number of clock cycles before they count. When a qualified fault is seen, the block enters a latched-off state, drops the voltage reference enable and records which fault tripped it as a one-hot cause code.

Once latched, the block only keeps the startup cell cycling between the lower and upper lockout thresholds, so that the supply swings as a saw tooth. It never signals a start-up phase. The latch releases only after the supply collapses below the deepest threshold. When not latched, the same hysteresis runs, and each time the supply reaches the upper threshold a one-cycle start pulse tells the rest of the controller to begin a start-up phase.

Top module: `prot_latch_sup`

## Requirements
- R1: After synchronous reset, latched is 0, reference enable is 1, startup-cell enable is 1, the cause code is 3'b000 and the start pulse is 0.
- R2: Supply overvoltage has no effect unless feedback-over-threshold is asserted in the same sampled cycle. Either flag alone never sets the latch.
- R3: Overvoltage with high feedback that is sampled on SLOW_BLANK consecutive clock edges sets the latch on the next edge, with cause 3'b001. Any cycle without the pair restarts the count.
- R4: Over-temperature sampled on SLOW_BLANK consecutive edges sets the latch on the next edge, with cause 3'b010. A gap restarts the count.
- R5: Secondary over-current sampled on FAST_BLANK consecutive edges sets the latch on the next edge, with cause 3'b100.
- R6: When several filtered faults qualify on the same edge, one cause bit is recorded. Secondary over-current wins over overvoltage, and overvoltage wins over over-temperature.
- R7: While latched, the reference enable is 0, and the cause code holds its value whatever the fault inputs do.
- R8: The latch and the cause code clear only on an edge where the below-6V flag is sampled high. Any other supply level, including below 8.5V, leaves the latch set.
- R9: The startup-cell enable turns off on the edge after the above-15V flag is sampled while it is on. It turns on again on the edge after the below-8.5V flag is sampled while it is off. This holds in both the latched and the unlatched state.
- R10: A one-cycle start pulse is issued together with the startup cell turning off, but only if the block is not latched after that edge. No start pulse is ever issued while latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ovp_i | input | 1 | Supply above overvoltage threshold |
| fb_over_i | input | 1 | Feedback above overload threshold |
| temp_hot_i | input | 1 | Junction over-temperature |
| sense_soc_i | input | 1 | Current sense above secondary over-current threshold |
| vcc_lt_clr_i | input | 1 | Supply below the latch release level (6V) |
| vcc_lt_on_i | input | 1 | Supply below the startup switch-on level (8.5V) |
| vcc_gt_off_i | input | 1 | Supply above the startup switch-off level (15V) |
| latched_o | output | 1 | Latched-off state |
| vref_en_o | output | 1 | Voltage reference enable |
| startup_en_o | output | 1 | Startup cell enable |
| start_pulse_o | output | 1 | One-cycle request to begin a start-up phase |
| cause_o | output | 3 | One-hot trip cause: bit0 overvoltage, bit1 over-temperature, bit2 secondary over-current |

## Verification
Two pairs of functions can fall in the same cycle. Two fault filters can complete on the same edge, and a latch trip can coincide with the startup cell switching off. The bench starts over-temperature and secondary over-current at offsets chosen so that both filters complete on one edge, and does the same for overvoltage with over-temperature. A behavioural reference model, compared on every clock, judges the recorded cause bit. The bench also raises the above-15V flag on the edge where a fault trips the latch, and checks that the startup cell still switches off while no start pulse appears.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef logic [2:0] cause_t;

    localparam cause_t CAUSE_NONE = 3'b000;
    localparam cause_t CAUSE_OV   = 3'b001;
    localparam cause_t CAUSE_OT   = 3'b010;
    localparam cause_t CAUSE_SOC  = 3'b100;

    typedef struct packed {
        logic soc;
        logic ov;
        logic ot;
    } fault_vec_t;

    // Secondary over-current first, then overvoltage, then over-temperature.
    function automatic cause_t pick_cause(fault_vec_t f);
        if (f.soc)     return CAUSE_SOC;
        else if (f.ov) return CAUSE_OV;
        else if (f.ot) return CAUSE_OT;
        else           return CAUSE_NONE;
    endfunction

    function automatic logic any_fault(fault_vec_t f);
        return f.soc | f.ov | f.ot;
    endfunction

endpackage

// File: rtl/prot_blank_filter.sv
module prot_blank_filter #(
    parameter int unsigned HOLD_CYC = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic qual_o
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

    logic [CW-1:0] run_q;

    generate
        if (HOLD_CYC == 0) begin : g_pass
            assign qual_o = raw_i;
            always_ff @(posedge clk) begin
                run_q <= '0;
            end
        end else begin : g_count
            always_ff @(posedge clk) begin
                if (rst || !raw_i) begin
                    run_q <= '0;
                end else if (run_q != LIMIT) begin
                    run_q <= run_q + 1'b1;
                end
            end
            assign qual_o = (run_q == LIMIT);
        end
    endgenerate

endmodule

// File: rtl/prot_fault_latch.sv
module prot_fault_latch
    import prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_vec_t flt_i,
    input  logic       release_i,
    output logic       latched_o,
    output logic       latched_nxt_o,
    output cause_t     cause_o
);
    logic   lat_q, lat_d;
    cause_t cause_q, cause_d;

    always_comb begin
        lat_d   = lat_q;
        cause_d = cause_q;
        if (lat_q && release_i) begin
            lat_d   = 1'b0;
            cause_d = CAUSE_NONE;
        end else if (!lat_q && any_fault(flt_i)) begin
            lat_d   = 1'b1;
            cause_d = pick_cause(flt_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            lat_q   <= lat_d;
            cause_q <= cause_d;
        end
    end

    assign latched_o     = lat_q;
    assign latched_nxt_o = lat_d;
    assign cause_o       = cause_q;

endmodule

// File: rtl/prot_uvlo_hyst.sv
module prot_uvlo_hyst (
    input  logic clk,
    input  logic rst,
    input  logic below_on_i,
    input  logic above_off_i,
    input  logic inhibit_start_i,
    output logic cell_en_o,
    output logic start_o
);
    logic cell_q, cell_d, start_q, turn_off;

    always_comb begin
        turn_off = cell_q && above_off_i;
        cell_d   = cell_q;
        if (turn_off)                  cell_d = 1'b0;
        else if (!cell_q && below_on_i) cell_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q  <= 1'b1;
            start_q <= 1'b0;
        end else begin
            cell_q  <= cell_d;
            start_q <= turn_off && !inhibit_start_i;
        end
    end

    assign cell_en_o = cell_q;
    assign start_o   = start_q;

endmodule

// File: rtl/prot_latch_sup.sv
module prot_latch_sup
    import prot_pkg::*;
#(
    parameter int unsigned SLOW_BLANK = 400,
    parameter int unsigned FAST_BLANK = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_ovp_i,
    input  logic       fb_over_i,
    input  logic       temp_hot_i,
    input  logic       sense_soc_i,
    input  logic       vcc_lt_clr_i,
    input  logic       vcc_lt_on_i,
    input  logic       vcc_gt_off_i,
    output logic       latched_o,
    output logic       vref_en_o,
    output logic       startup_en_o,
    output logic       start_pulse_o,
    output logic [2:0] cause_o
);
    fault_vec_t raw, qual;
    logic       lat_nxt;
    cause_t     cause;

    // Overvoltage only counts while feedback is out of its range.
    assign raw.ov  = vcc_ovp_i & fb_over_i;
    assign raw.ot  = temp_hot_i;
    assign raw.soc = sense_soc_i;

    prot_blank_filter #(.HOLD_CYC(SLOW_BLANK)) u_flt_ov (
        .clk(clk), .rst(rst), .raw_i(raw.ov), .qual_o(qual.ov));
    prot_blank_filter #(.HOLD_CYC(SLOW_BLANK)) u_flt_ot (
        .clk(clk), .rst(rst), .raw_i(raw.ot), .qual_o(qual.ot));
    prot_blank_filter #(.HOLD_CYC(FAST_BLANK)) u_flt_soc (
        .clk(clk), .rst(rst), .raw_i(raw.soc), .qual_o(qual.soc));

    prot_fault_latch u_latch (
        .clk(clk), .rst(rst), .flt_i(qual), .release_i(vcc_lt_clr_i),
        .latched_o(latched_o), .latched_nxt_o(lat_nxt), .cause_o(cause));

    prot_uvlo_hyst u_uvlo (
        .clk(clk), .rst(rst), .below_on_i(vcc_lt_on_i),
        .above_off_i(vcc_gt_off_i), .inhibit_start_i(lat_nxt),
        .cell_en_o(startup_en_o), .start_o(start_pulse_o));

    assign vref_en_o = ~latched_o;
    assign cause_o   = cause;

endmodule

// File: rtl/prot_latch_sup_chk.sv
module prot_latch_sup_chk (
    input logic       clk,
    input logic       rst,
    input logic       vcc_ovp_i,
    input logic       fb_over_i,
    input logic       vcc_lt_clr_i,
    input logic       vcc_lt_on_i,
    input logic       vcc_gt_off_i,
    input logic       latched_o,
    input logic       vref_en_o,
    input logic       startup_en_o,
    input logic       start_pulse_o,
    input logic [2:0] cause_o
);
    p_vref_off_r7: assert property (@(posedge clk) disable iff (rst)
        latched_o |-> !vref_en_o);

    p_cause_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (latched_o && $past(latched_o)) |-> $stable(cause_o));

    p_cause_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause_o) && (latched_o == (cause_o != 3'b000)));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(latched_o) |-> $past(vcc_lt_clr_i));

    p_ov_qualified_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(latched_o) && cause_o == 3'b001) |-> $past(vcc_ovp_i && fb_over_i, 2));

    p_cell_off_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(startup_en_o) |-> $past(vcc_gt_off_i));

    p_cell_on_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(startup_en_o) |-> $past(vcc_lt_on_i));

    p_start_unlatched_r10: assert property (@(posedge clk) disable iff (rst)
        start_pulse_o |-> (!latched_o && $fell(startup_en_o)));

    p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
        start_pulse_o |=> !start_pulse_o);
endmodule

bind prot_latch_sup prot_latch_sup_chk u_chk (
    .clk(clk), .rst(rst), .vcc_ovp_i(vcc_ovp_i), .fb_over_i(fb_over_i),
    .vcc_lt_clr_i(vcc_lt_clr_i), .vcc_lt_on_i(vcc_lt_on_i),
    .vcc_gt_off_i(vcc_gt_off_i), .latched_o(latched_o), .vref_en_o(vref_en_o),
    .startup_en_o(startup_en_o), .start_pulse_o(start_pulse_o),
    .cause_o(cause_o));

// File: tb/prot_latch_sup_bench.sv
module prot_latch_sup_bench;
    localparam int SLOW = 20;
    localparam int FAST = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ovp = 0, fb = 0, hot = 0, soc = 0, lt6 = 0, lt85 = 0, gt15 = 0;
    logic lat, vref, su, stp;
    logic [2:0] cause;

    always #10 clk = ~clk;

    prot_latch_sup #(.SLOW_BLANK(SLOW), .FAST_BLANK(FAST)) u_prot_latch_sup (
        .clk(clk), .rst(rst), .vcc_ovp_i(ovp), .fb_over_i(fb),
        .temp_hot_i(hot), .sense_soc_i(soc), .vcc_lt_clr_i(lt6),
        .vcc_lt_on_i(lt85), .vcc_gt_off_i(gt15), .latched_o(lat),
        .vref_en_o(vref), .startup_en_o(su), .start_pulse_o(stp),
        .cause_o(cause));

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int   n_ov = 0, n_ot = 0, n_soc = 0;
    logic m_lat = 0, m_su = 1, m_stp = 0;
    logic [2:0] m_cause = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit f_ov, f_ot, f_soc;
        logic n_lat, n_su;
        logic [2:0] n_cause;
        if (rst) begin
            n_ov = 0; n_ot = 0; n_soc = 0;
            m_lat = 0; m_su = 1; m_stp = 0; m_cause = 0;
            return;
        end
        f_ov = (n_ov == SLOW); f_ot = (n_ot == SLOW); f_soc = (n_soc == FAST);
        n_lat = m_lat; n_cause = m_cause;
        if (m_lat && lt6) begin
            n_lat = 0; n_cause = 0;
        end else if (!m_lat && (f_ov || f_ot || f_soc)) begin
            n_lat = 1;
            n_cause = f_soc ? 3'd4 : (f_ov ? 3'd1 : 3'd2);
        end
        n_su = m_su;
        if (m_su && gt15) n_su = 0;
        else if (!m_su && lt85) n_su = 1;
        m_stp = m_su && gt15 && !n_lat;
        m_lat = n_lat; m_cause = n_cause; m_su = n_su;
        n_ov  = (ovp && fb) ? ((n_ov < SLOW) ? n_ov + 1 : SLOW) : 0;
        n_ot  = hot ? ((n_ot < SLOW) ? n_ot + 1 : SLOW) : 0;
        n_soc = soc ? ((n_soc < FAST) ? n_soc + 1 : FAST) : 0;
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            #1;
            if (!rst) begin
                check(cur_req, "latched", lat, m_lat);
                check(cur_req, "vref_en", vref, !m_lat);
                check(cur_req, "startup_en", su, m_su);
                check(cur_req, "start_pulse", stp, m_stp);
                check(cur_req, "cause", cause, m_cause);
            end
        end
    endtask

    // 0: below 6V, 1: below 8.5V, 2: mid range, 3: above 15V
    task automatic vcc(int lvl);
        lt6  = (lvl == 0);
        lt85 = (lvl <= 1);
        gt15 = (lvl == 3);
    endtask

    task automatic release_latch();
        cur_req = "R8";
        ovp = 0; fb = 0; hot = 0; soc = 0;
        vcc(1); step(3);
        check("R8", "held below 8.5V", lat, 1);
        vcc(0); step(1);
        check("R8", "released", lat, 0);
        check("R8", "cause cleared", cause, 0);
        vcc(2); step(2);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vcc(2);
        step(3);
        #1 rst = 0;
        cur_req = "R1";
        check("R1", "reset latched", lat, 0);
        check("R1", "reset vref_en", vref, 1);
        check("R1", "reset startup_en", su, 1);
        check("R1", "reset cause", cause, 0);
        check("R1", "reset start", stp, 0);
        step(2);

        // R9 / R10 unlatched hysteresis with start pulse
        cur_req = "R10";
        vcc(3); step(1);
        check("R10", "start pulse", stp, 1);
        check("R9", "cell off", su, 0);
        step(2);
        vcc(2); step(2);
        cur_req = "R9";
        vcc(1); step(1);
        check("R9", "cell back on", su, 1);
        vcc(2); step(2);

        // R2: unqualified overvoltage
        cur_req = "R2";
        ovp = 1; fb = 0; step(3 * SLOW);
        ovp = 0; fb = 1; step(3 * SLOW);
        check("R2", "no latch", lat, 0);
        fb = 0;

        // R3: interrupted, then continuous
        cur_req = "R3";
        ovp = 1; fb = 1; step(SLOW - 1);
        fb = 0; step(1);
        fb = 1; step(SLOW - 1);
        check("R3", "restart after gap", lat, 0);
        step(1);
        check("R3", "not yet", lat, 0);
        step(1);
        check("R3", "tripped", lat, 1);
        check("R3", "cause ov", cause, 1);

        // R7: more faults while latched
        cur_req = "R7";
        hot = 1; soc = 1; step(2 * SLOW);
        check("R7", "cause held", cause, 1);
        check("R7", "vref off", vref, 0);
        hot = 0; soc = 0; ovp = 0; fb = 0;
        // R9/R10 while latched
        cur_req = "R10";
        vcc(3); step(1);
        check("R10", "no start while latched", stp, 0);
        check("R9", "cell off latched", su, 0);
        vcc(1); step(1);
        check("R9", "cell on latched", su, 1);
        release_latch();

        // R4 over-temperature
        cur_req = "R4";
        hot = 1; step(SLOW - 2); hot = 0; step(1);
        hot = 1; step(SLOW + 1);
        check("R4", "tripped", lat, 1);
        check("R4", "cause ot", cause, 2);
        release_latch();

        // R5 secondary over-current
        cur_req = "R5";
        soc = 1; step(FAST);
        check("R5", "not yet", lat, 0);
        step(1);
        check("R5", "tripped", lat, 1);
        check("R5", "cause soc", cause, 4);
        release_latch();

        // R6: over-temperature and secondary over-current complete together
        cur_req = "R6";
        hot = 1; step(SLOW - FAST);
        soc = 1; step(FAST + 1);
        check("R6", "soc wins", cause, 4);
        release_latch();

        // R6: overvoltage and over-temperature together, trip coinciding with 15V
        cur_req = "R6";
        hot = 1; ovp = 1; fb = 1; step(SLOW);
        vcc(3); step(1);
        check("R6", "ov wins", cause, 1);
        check("R10", "no start on trip edge", stp, 0);
        check("R9", "cell off on trip edge", su, 0);
        release_latch();
        step(5);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule